// File: doc/BRIEF.md
# Pipeline Hazard and Forwarding Unit

This block is the hazard control for a five-stage, in-order pipeline. The stages are fetch, decode, execute, memory and writeback. Each cycle it looks at the instruction in decode and compares its source register fields with the destination registers of the two older instructions now in execute and memory. From that comparison it produces three results. The first is a pair of forwarding selects for the ALU operands; these are registered so that they line up with the instruction once it reaches execute. The second is a hold request that freezes the program counter and the fetch/decode register. The third is a marker showing that the slot now in execute is an inserted bubble.

The unit also settles jump and branch-if-equal in decode. Each of these instructions is followed by one delay-slot instruction, which always executes, so a redirect never flushes anything. Jump has no register sources and never holds. Branch-if-equal compares the two register-file read values it is given. It takes no forwarded data in decode, so it holds for as long as an older instruction in execute or memory still has to write one of its sources. Register-file writes happen in the first half of the cycle and reads in the second, so a producer in writeback needs neither forwarding nor a hold. The register file, ALU and memories stay outside the block.

Top module: `fwd_hazard_unit`

## Requirements
- R1: After reset, with a nop in decode, hold, redirect, ex_is_bubble, fwd_a and fwd_b are all 0.
- R2: One cycle after an ALU-consuming instruction leaves decode, fwd_a (for rs) and fwd_b (for rt) give the operand source. Code 1 means the execute/memory register, used when the instruction directly ahead writes that register. Code 2 means the memory/writeback register, used when the instruction two ahead writes it. Code 0 means the register file. Code 3 never appears.
- R3: When both older instructions write the same source register, the younger one (code 1) wins.
- R4: Register 0 never causes forwarding or a hold.
- R5: A load followed directly by an instruction whose ALU operands depend on it raises hold for exactly one cycle. The reissued instruction then gets code 2.
- R6: In the cycle after hold, ex_is_bubble is 1 and both selects are 0. Decode keeps the same instruction while hold is 1.
- R7: Branch-if-equal raises hold while a nonzero rs or rt of the branch is written by the instruction in execute or in memory. It takes no forwarding. A writer in writeback does not hold it.
- R8: When branch-if-equal is not held and rf_a equals rf_b, redirect is 1 and redirect_pc equals the target field. When rf_a and rf_b differ, redirect is 0. Redirect is never 1 while hold is 1.
- R9: Jump raises redirect with redirect_pc equal to the target field in the cycle it is in decode, and it never raises hold.
- R10: Opcode codes are nop 0, load 1, store 2, add 3, sub 4, add-immediate 5, shift-left 6, shift-right 7, jump 8, branch-if-equal 9. Add, sub, shift-left and shift-right write rd; load and add-immediate write rt. Add, sub, store and branch read rs and rt; load, add-immediate and the shifts read rs only. Codes 10 to 15 behave as nop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| id_op | input | 4 | Opcode of the instruction in decode |
| id_rs | input | $clog2(NREG) | First source register field |
| id_rt | input | $clog2(NREG) | Second source / immediate-form destination field |
| id_rd | input | $clog2(NREG) | Register-form destination field |
| id_tgt | input | TGT_W | Jump/branch absolute target |
| rf_a | input | XLEN | Register-file value read for rs in decode |
| rf_b | input | XLEN | Register-file value read for rt in decode |
| hold | output | 1 | Freeze PC and fetch/decode register, send a nop to execute |
| ex_is_bubble | output | 1 | The slot now in execute is an inserted nop |
| fwd_a | output | 2 | Operand A source select for execute |
| fwd_b | output | 2 | Operand B source select for execute |
| redirect | output | 1 | Load redirect_pc into the PC |
| redirect_pc | output | TGT_W | Jump/branch target |

## Verification
The assertions assume that the surrounding pipeline keeps the same instruction and operand values in decode for every cycle in which hold is 1. Under that assumption a held load-use instruction drops its hold on the next cycle. The stimulus meets this assumption: the bench reissues the same instruction until the hold clears. Register fields are drawn from a small set so that matches, same-register collisions with both older stages, and register 0 show up often. Operand values are equal half the time, so branches are taken and not taken in similar numbers.

// File: rtl/hz_pkg.sv
package hz_pkg;

   localparam logic [3:0] OP_NOP = 4'd0;
   localparam logic [3:0] OP_LW  = 4'd1;
   localparam logic [3:0] OP_SW  = 4'd2;
   localparam logic [3:0] OP_ADD = 4'd3;
   localparam logic [3:0] OP_SUB = 4'd4;
   localparam logic [3:0] OP_AI  = 4'd5;
   localparam logic [3:0] OP_SHL = 4'd6;
   localparam logic [3:0] OP_SHR = 4'd7;
   localparam logic [3:0] OP_JMP = 4'd8;
   localparam logic [3:0] OP_BEQ = 4'd9;

   localparam logic [1:0] SRC_RF  = 2'd0;
   localparam logic [1:0] SRC_EXM = 2'd1;
   localparam logic [1:0] SRC_MWB = 2'd2;

   typedef struct packed {
      logic uses_rs;
      logic uses_rt;
      logic alu_in;
      logic wr;
      logic wr_rt;
      logic ld;
      logic jmp;
      logic beq;
   } op_info_t;

   function automatic op_info_t decode_op(logic [3:0] op);
      op_info_t i;
      i = '0;
      case (op)
         OP_LW:  begin i.uses_rs = 1'b1; i.alu_in = 1'b1; i.wr = 1'b1;
                       i.wr_rt = 1'b1; i.ld = 1'b1; end
         OP_SW:  begin i.uses_rs = 1'b1; i.uses_rt = 1'b1; i.alu_in = 1'b1; end
         OP_ADD,
         OP_SUB: begin i.uses_rs = 1'b1; i.uses_rt = 1'b1; i.alu_in = 1'b1;
                       i.wr = 1'b1; end
         OP_AI:  begin i.uses_rs = 1'b1; i.alu_in = 1'b1; i.wr = 1'b1;
                       i.wr_rt = 1'b1; end
         OP_SHL,
         OP_SHR: begin i.uses_rs = 1'b1; i.alu_in = 1'b1; i.wr = 1'b1; end
         OP_JMP: i.jmp = 1'b1;
         OP_BEQ: begin i.uses_rs = 1'b1; i.uses_rt = 1'b1; i.beq = 1'b1; end
         default: ;
      endcase
      return i;
   endfunction

endpackage

// File: rtl/hz_src_match.sv
module hz_src_match #(
   parameter int RA_W = 5
) (
   input  logic [RA_W-1:0] src,
   input  logic            used,
   input  logic            ex_vld,
   input  logic            ex_ld,
   input  logic [RA_W-1:0] ex_dst,
   input  logic            mem_vld,
   input  logic [RA_W-1:0] mem_dst,
   output logic [1:0]      sel,
   output logic            ld_hit,
   output logic            any_hit
);
   import hz_pkg::*;

   logic live, hit_ex, hit_mem;

   always_comb begin
      live    = used && (src != '0);
      hit_ex  = live && ex_vld  && (ex_dst  == src);
      hit_mem = live && mem_vld && (mem_dst == src);
      ld_hit  = hit_ex && ex_ld;
      any_hit = hit_ex || hit_mem;
      if (hit_ex)       sel = SRC_EXM;
      else if (hit_mem) sel = SRC_MWB;
      else              sel = SRC_RF;
   end
endmodule

// File: rtl/hz_branch.sv
module hz_branch #(
   parameter int XLEN  = 32,
   parameter int TGT_W = 15
) (
   input  logic             is_jmp,
   input  logic             is_beq,
   input  logic             hold,
   input  logic [XLEN-1:0]  val_a,
   input  logic [XLEN-1:0]  val_b,
   input  logic [TGT_W-1:0] tgt,
   output logic             take,
   output logic [TGT_W-1:0] dest
);
   logic same;

   always_comb begin
      same = (val_a == val_b);
      take = !hold && (is_jmp || (is_beq && same));
      dest = tgt;
   end
endmodule

// File: rtl/fwd_hazard_unit.sv
module fwd_hazard_unit #(
   parameter int NREG  = 32,
   parameter int XLEN  = 32,
   parameter int TGT_W = 15
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [3:0]              id_op,
   input  logic [$clog2(NREG)-1:0] id_rs,
   input  logic [$clog2(NREG)-1:0] id_rt,
   input  logic [$clog2(NREG)-1:0] id_rd,
   input  logic [TGT_W-1:0]        id_tgt,
   input  logic [XLEN-1:0]         rf_a,
   input  logic [XLEN-1:0]         rf_b,
   output logic                    hold,
   output logic                    ex_is_bubble,
   output logic [1:0]              fwd_a,
   output logic [1:0]              fwd_b,
   output logic                    redirect,
   output logic [TGT_W-1:0]        redirect_pc
);
   import hz_pkg::*;

   localparam int RA_W = $clog2(NREG);
   localparam int NSRC = 2;

   generate
      if (NREG < 2 || (NREG & (NREG - 1)) != 0) begin : g_bad_nreg
         $error("NREG must be a power of two of at least 2");
      end
      if (TGT_W < 1 || TGT_W > XLEN) begin : g_bad_tgt
         $error("TGT_W must lie in 1..XLEN");
      end
   endgenerate

   op_info_t        inf;
   logic [RA_W-1:0] dst_id;

   always_comb begin
      inf    = decode_op(id_op);
      dst_id = inf.wr_rt ? id_rt : id_rd;
   end

   logic            ex_vld, ex_ld, mem_vld;
   logic [RA_W-1:0] ex_dst, mem_dst;

   logic [NSRC-1:0][RA_W-1:0] src_v;
   logic [NSRC-1:0]           used_v;
   logic [NSRC-1:0][1:0]      sel_v;
   logic [NSRC-1:0]           ld_hit_v, any_hit_v;

   assign src_v  = {id_rt, id_rs};
   assign used_v = {inf.uses_rt, inf.uses_rs};

   generate
      for (genvar g = 0; g < NSRC; g++) begin : g_src
         hz_src_match #(.RA_W(RA_W)) u_match (
            .src     (src_v[g]),
            .used    (used_v[g]),
            .ex_vld  (ex_vld),
            .ex_ld   (ex_ld),
            .ex_dst  (ex_dst),
            .mem_vld (mem_vld),
            .mem_dst (mem_dst),
            .sel     (sel_v[g]),
            .ld_hit  (ld_hit_v[g]),
            .any_hit (any_hit_v[g])
         );
      end
   endgenerate

   always_comb begin
      hold = (inf.alu_in && (|ld_hit_v)) || (inf.beq && (|any_hit_v));
   end

   hz_branch #(.XLEN(XLEN), .TGT_W(TGT_W)) u_branch (
      .is_jmp (inf.jmp),
      .is_beq (inf.beq),
      .hold   (hold),
      .val_a  (rf_a),
      .val_b  (rf_b),
      .tgt    (id_tgt),
      .take   (redirect),
      .dest   (redirect_pc)
   );

   logic pass;
   assign pass = !hold && inf.alu_in;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ex_vld       <= 1'b0;
         ex_ld        <= 1'b0;
         ex_dst       <= '0;
         mem_vld      <= 1'b0;
         mem_dst      <= '0;
         fwd_a        <= SRC_RF;
         fwd_b        <= SRC_RF;
         ex_is_bubble <= 1'b0;
      end else begin
         mem_vld      <= ex_vld;
         mem_dst      <= ex_dst;
         ex_vld       <= !hold && inf.wr;
         ex_ld        <= !hold && inf.ld;
         ex_dst       <= dst_id;
         fwd_a        <= pass ? sel_v[0] : SRC_RF;
         fwd_b        <= pass ? sel_v[1] : SRC_RF;
         ex_is_bubble <= hold;
      end
   end
endmodule

// File: rtl/fwd_hazard_unit_chk.sv
module fwd_hazard_unit_chk (
   input logic       clk,
   input logic       rst_n,
   input logic [3:0] id_op,
   input logic       hold,
   input logic       ex_is_bubble,
   input logic [1:0] fwd_a,
   input logic [1:0] fwd_b,
   input logic       redirect
);
   p_jump_never_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (id_op == 4'd8) |-> !hold);

   p_no_redirect_in_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      hold |-> !redirect);

   p_bubble_after_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      hold |=> ex_is_bubble);

   p_bubble_has_no_fwd_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ex_is_bubble |-> (fwd_a == 2'd0 && fwd_b == 2'd0));

   p_code_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (fwd_a != 2'd3) && (fwd_b != 2'd3));

   p_loaduse_one_cycle_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (hold && id_op != 4'd9) |=> !hold);
endmodule

bind fwd_hazard_unit fwd_hazard_unit_chk u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .id_op        (id_op),
   .hold         (hold),
   .ex_is_bubble (ex_is_bubble),
   .fwd_a        (fwd_a),
   .fwd_b        (fwd_b),
   .redirect     (redirect)
);

// File: tb/fwd_hazard_unit_bench.sv
`timescale 1ns/1ps
module fwd_hazard_unit_bench;
   localparam int NREG  = 32;
   localparam int XLEN  = 32;
   localparam int TGT_W = 15;
   localparam int RA_W  = 5;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic [3:0]       id_op = 4'd0;
   logic [RA_W-1:0]  id_rs = '0, id_rt = '0, id_rd = '0;
   logic [TGT_W-1:0] id_tgt = '0;
   logic [XLEN-1:0]  rf_a = '0, rf_b = '0;
   logic             hold, ex_is_bubble, redirect;
   logic [1:0]       fwd_a, fwd_b;
   logic [TGT_W-1:0] redirect_pc;

   always #2.5 clk = ~clk;

   fwd_hazard_unit #(.NREG(NREG), .XLEN(XLEN), .TGT_W(TGT_W)) u_fwd_hazard_unit (
      .clk(clk), .rst_n(rst_n), .id_op(id_op), .id_rs(id_rs), .id_rt(id_rt),
      .id_rd(id_rd), .id_tgt(id_tgt), .rf_a(rf_a), .rf_b(rf_b), .hold(hold),
      .ex_is_bubble(ex_is_bubble), .fwd_a(fwd_a), .fwd_b(fwd_b),
      .redirect(redirect), .redirect_pc(redirect_pc));

   int n_cmp = 0, n_bad = 0;

   // bench model of the two older stages
   bit              m_ex_vld, m_ex_ld, m_mem_vld;
   logic [RA_W-1:0] m_ex_dst, m_mem_dst;
   int              p_fa, p_fb;
   bit              p_bub;
   string           p_ta = "R1", p_tb = "R1";

   function automatic bit b_writes(int op); return op inside {1, 3, 4, 5, 6, 7}; endfunction
   function automatic bit b_dst_rt(int op); return op inside {1, 5}; endfunction
   function automatic bit b_rs(int op);     return op inside {1, 2, 3, 4, 5, 6, 7, 9}; endfunction
   function automatic bit b_rt(int op);     return op inside {2, 3, 4, 9}; endfunction
   function automatic bit b_alu(int op);    return op inside {1, 2, 3, 4, 5, 6, 7}; endfunction
   function automatic bit hit_ex(logic [RA_W-1:0] r);
      return r != 0 && m_ex_vld && m_ex_dst == r;
   endfunction
   function automatic bit hit_mem(logic [RA_W-1:0] r);
      return r != 0 && m_mem_vld && m_mem_dst == r;
   endfunction
   function automatic int exp_sel(bit used, logic [RA_W-1:0] r);
      if (used && hit_ex(r))  return 1;
      if (used && hit_mem(r)) return 2;
      return 0;
   endfunction
   function automatic string ftag(int op, logic [RA_W-1:0] r);
      if (op >= 10)               return "R10";
      if (r == 0)                 return "R4";
      if (hit_ex(r) && hit_mem(r)) return "R3";
      return "R2";
   endfunction

   task automatic chk(input string req, input string what, input longint act, input longint exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic evaluate(output bit e_hold);
      int  op;
      bit  ld_use, beq_st, e_red;
      string ht;
      op = int'(id_op);
      ld_use = b_alu(op) && m_ex_ld &&
               ((b_rs(op) && hit_ex(id_rs)) || (b_rt(op) && hit_ex(id_rt)));
      beq_st = (op == 9) && (hit_ex(id_rs) || hit_mem(id_rs) ||
                             hit_ex(id_rt) || hit_mem(id_rt));
      e_hold = ld_use || beq_st;
      e_red  = !e_hold && (op == 8 || (op == 9 && rf_a == rf_b));
      ht = (op >= 10) ? "R10" : (op == 9) ? "R7" : (op == 8) ? "R9" : "R5";
      chk(ht, "hold", hold, e_hold);
      chk((op == 8) ? "R9" : "R8", "redirect", redirect, e_red);
      if (e_red) chk((op == 8) ? "R9" : "R8", "redirect_pc", redirect_pc, id_tgt);
      chk(p_ta, "fwd_a", fwd_a, p_fa);
      chk(p_tb, "fwd_b", fwd_b, p_fb);
      chk("R6", "ex_is_bubble", ex_is_bubble, p_bub);
      // values registered at the coming edge
      p_bub = e_hold;
      p_fa  = (!e_hold && b_alu(op)) ? exp_sel(b_rs(op), id_rs) : 0;
      p_fb  = (!e_hold && b_alu(op)) ? exp_sel(b_rt(op), id_rt) : 0;
      p_ta  = e_hold ? "R6" : ftag(op, id_rs);
      p_tb  = e_hold ? "R6" : ftag(op, id_rt);
      m_mem_vld = m_ex_vld;
      m_mem_dst = m_ex_dst;
      m_ex_vld  = !e_hold && b_writes(op);
      m_ex_ld   = !e_hold && (op == 1);
      m_ex_dst  = b_dst_rt(op) ? id_rt : id_rd;
   endtask

   task automatic issue(input int op, input int rs, input int rt, input int rd,
                        input int tgt, input logic [XLEN-1:0] a, input logic [XLEN-1:0] b);
      bit h;
      id_op = 4'(op); id_rs = RA_W'(rs); id_rt = RA_W'(rt); id_rd = RA_W'(rd);
      id_tgt = TGT_W'(tgt); rf_a = a; rf_b = b;
      do begin
         #0.5;
         evaluate(h);
         @(negedge clk);
      end while (h);
   endtask

   task automatic run();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #0.5;
      // R1: quiet outputs after reset
      chk("R1", "hold", hold, 0);
      chk("R1", "redirect", redirect, 0);
      chk("R1", "ex_is_bubble", ex_is_bubble, 0);
      chk("R1", "fwd_a", fwd_a, 0);
      chk("R1", "fwd_b", fwd_b, 0);
      @(negedge clk);
      // R2: distance one and two
      issue(3, 2, 3, 1, 0, 0, 0);
      issue(0, 0, 0, 0, 0, 0, 0);
      issue(3, 1, 1, 4, 0, 0, 0);
      issue(4, 4, 1, 5, 0, 0, 0);
      // R5: load then dependent add
      issue(1, 0, 2, 0, 0, 0, 0);
      issue(3, 2, 7, 8, 0, 0, 0);
      // R3: both older stages write r3
      issue(3, 9, 9, 3, 0, 0, 0);
      issue(3, 9, 9, 3, 0, 0, 0);
      issue(4, 3, 3, 10, 0, 0, 0);
      // R4: register 0
      issue(3, 1, 1, 0, 0, 0, 0);
      issue(1, 0, 0, 0, 0, 0, 0);
      issue(3, 0, 0, 6, 0, 0, 0);
      // R7 and R8: branch waits for writeback, then taken
      issue(3, 2, 2, 11, 0, 0, 0);
      issue(9, 11, 11, 0, 16'h1234, 32'd7, 32'd7);
      issue(9, 2, 3, 0, 15'h0042, 32'd1, 32'd2);
      // R9: jump right after a load never holds
      issue(1, 0, 12, 0, 0, 0, 0);
      issue(8, 12, 12, 0, 15'h7ABC, 0, 0);
      // R10: undefined code 15 behaves as nop
      issue(5, 0, 13, 0, 0, 0, 0);
      issue(15, 13, 13, 13, 0, 0, 0);
      issue(3, 13, 0, 14, 0, 0, 0);
      for (int i = 0; i < 3000; i++) begin
         int op;
         logic [XLEN-1:0] a, b;
         op = $urandom_range(0, 10);
         if (op == 10) op = $urandom_range(10, 15);
         a = $urandom;
         b = ($urandom_range(0, 1) != 0) ? a : XLEN'($urandom);
         issue(op, $urandom_range(0, 3), $urandom_range(0, 3), $urandom_range(0, 3),
               $urandom_range(0, 32767), a, b);
      end
   endtask

   initial begin
      void'($urandom(32'h0D15EA5E));
      fork
         run();
         begin
            repeat (100000) @(posedge clk);
            n_bad++;
            $display("FAIL R1 watchdog: actual hung expected finished");
         end
      join_any
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule